// File: doc/BRIEF.md
# Pseudoexhaustive Test Signal Generator

This block produces the stimulus for a pseudoexhaustive self-test. It does not count through all 2^n input patterns of a circuit under test. It steps through a short stored vector set on a few shared test signal lines, and a fanout map ties each circuit input to one of those lines. Several circuit inputs can share one line. Each output cone that depends on only a few inputs is still exercised with every combination of its own inputs.

Two vector sets are built in, and the `mode` input picks one when a run starts.

- **Mode 0** drives two lines over four vectors. It suits a circuit whose outputs each depend on one of two overlapping input pairs, where the two outer inputs never meet in a single cone and can therefore be tied together.
- **Mode 1** drives four lines over five vectors. Every pair of those lines takes all four value combinations.

A single-cycle `start` launches a run. The vectors appear one per clock on `drive` while `vec_idx` reports their number. A one-cycle `done` closes the run.

Top module: `pex_tsg`

## Requirements
- R1: While reset is active, and in the first cycle after it, `drive` and `vec_idx` are zero and `done` is low.
- R2: `start` sampled high while idle begins a run. The first vector is on `drive` in the cycle after that edge, with `vec_idx` equal to 0. Each further clock advances `vec_idx` by one and applies the next vector.
- R3: In mode 0 (`mode`=0) the run has 4 vectors. Test signal 0 takes the values 1,1,0,0 over vectors 0..3, and test signal 1 takes 1,0,1,0.
- R4: In mode 1 (`mode`=1) the run has 5 vectors. Vector k (k = 0..3) has every one of test signals 0..3 at 1 except signal 3-k, which is 0. Vector 4 is all zeros.
- R5: Circuit input i carries the test signal selected by the 2-bit field at bits [2i+1:2i] of `MAP_A` in mode 0 or of `MAP_B` in mode 1. By default `MAP_A` ties inputs 0 and 2 to signal 0 and inputs 1 and 3 to signal 1, and `MAP_B` ties input i to signal i.
- R6: `done` is high for exactly one cycle, the cycle after the last vector. In that cycle and while idle, `drive` and `vec_idx` are zero.
- R7: `start` is ignored while a run is in progress, and a change of `mode` during a run does not alter it. `mode` is sampled only on the edge that starts a run.
- R8: Over one complete run, every pair of circuit inputs that are mapped to different test signals takes all four value combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when sampled high while idle |
| mode | input | 1 | Vector set select: 0 = two-signal set, 1 = four-signal set |
| drive | output | N | Values for the circuit-under-test inputs |
| vec_idx | output | 3 | Number of the vector currently applied |
| done | output | 1 | One-cycle pulse after the final vector |

## Verification
The assertions assume that reset is held low for at least one clock edge before any run begins. They also assume that every field of the two fanout maps names a test signal that exists in its mode: 0 or 1 for `MAP_A`, and 0 to 3 for `MAP_B`.

The stimulus releases reset only after several cycles. It keeps both maps at their defaults, and it changes `start` and `mode` only at falling edges. It also holds `start` high, with the opposite mode, for most of one run, so that the ignored-start path is exercised without `start` ever reaching an idle cycle by accident.

// File: rtl/pex_tsg.sv
module pex_tsg #(
  parameter int N = 4,
  parameter logic [2*N-1:0] MAP_A = 8'b01_00_01_00,
  parameter logic [2*N-1:0] MAP_B = 8'b11_10_01_00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode,
  output logic [N-1:0] drive,
  output logic [2:0]   vec_idx,
  output logic         done
);
  localparam int SELW = 2;
  localparam logic [2:0] LAST_A = 3'd3;
  localparam logic [2:0] LAST_B = 3'd4;

  logic       run, mode_q;
  logic [2:0] idx;
  logic [3:0] sig;
  logic [2:0] last;

  assign last = mode_q ? LAST_B : LAST_A;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      mode_q <= 1'b0;
      idx    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run    <= 1'b1;
          mode_q <= mode;
          idx    <= '0;
        end
      end else if (idx == last) begin
        run  <= 1'b0;
        idx  <= '0;
        done <= 1'b1;
      end else begin
        idx <= idx + 3'd1;
      end
    end
  end

  always_comb begin
    sig = 4'b0000;
    if (!mode_q) begin
      case (idx)
        3'd0:    sig = 4'b0011;
        3'd1:    sig = 4'b0001;
        3'd2:    sig = 4'b0010;
        default: sig = 4'b0000;
      endcase
    end else begin
      case (idx)
        3'd0:    sig = 4'b0111;
        3'd1:    sig = 4'b1011;
        3'd2:    sig = 4'b1101;
        3'd3:    sig = 4'b1110;
        default: sig = 4'b0000;
      endcase
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_fan
    logic [SELW-1:0] sel;
    assign sel      = mode_q ? MAP_B[i*SELW +: SELW] : MAP_A[i*SELW +: SELW];
    assign drive[i] = run & sig[sel];
  end

  assign vec_idx = run ? idx : 3'd0;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && idx != 3'd0 |-> $past(run) && idx == $past(idx) + 3'd1);        // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                          // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run) && $past(idx) == $past(last));                        // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> drive == '0 && vec_idx == 3'd0);                                 // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> $stable(mode_q));                                   // R7
  AST_A_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    run && !mode_q |-> idx <= LAST_A);                                        // R3
  AST_B_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    run && mode_q && idx != LAST_B |-> $countones(sig) == 3);                 // R4
endmodule

// File: tb/pex_tsg_tb.sv
module pex_tsg_tb;
  localparam int N = 4;
  localparam logic [2*N-1:0] MA = 8'b01_00_01_00;
  localparam logic [2*N-1:0] MB = 8'b11_10_01_00;

  typedef struct {
    logic [N-1:0] drv;
    logic [2:0]   idx;
    logic         dn;
    logic         act;
    logic         md;
    string        req;
  } item_t;

  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic [N-1:0] drive;
  logic [2:0] vec_idx;
  logic done;
  int checks = 0, fails = 0;
  item_t q[$];
  logic [3:0] cov [N][N];

  always #2.5 clk = ~clk;

  pex_tsg #(.N(N), .MAP_A(MA), .MAP_B(MB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .drive(drive), .vec_idx(vec_idx), .done(done));

  function automatic logic tsig(logic m, int k, int s);
    if (!m) return (s == 0) ? (k < 2) : (k % 2 == 0);
    return (k < 4) ? (s != 3 - k) : 1'b0;
  endfunction

  function automatic int msel(logic m, int i);
    return m ? int'(MB[2*i +: 2]) : int'(MA[2*i +: 2]);
  endfunction

  task automatic check(string req, logic ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_cov();
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) cov[i][j] = 4'b0;
  endtask

  // driver: launches one run, optionally disturbing start/mode (R7)
  task automatic run_seq(logic m, logic disturb);
    int len = m ? 5 : 4;
    item_t it;
    @(negedge clk);
    start = 1; mode = m;
    for (int k = 0; k < len; k++) begin
      it.drv = '0;
      for (int i = 0; i < N; i++) it.drv[i] = tsig(m, k, msel(m, i));
      it.idx = 3'(k); it.dn = 0; it.act = 1; it.md = m;
      it.req = disturb ? "R7" : (m ? "R4/R5" : "R3/R5");
      q.push_back(it);
    end
    it.drv = '0; it.idx = 0; it.dn = 1; it.act = 0; it.md = m; it.req = "R6";
    q.push_back(it);
    it.dn = 0; it.req = "R6";
    q.push_back(it); q.push_back(it);
    @(negedge clk);
    start = disturb; mode = disturb ? ~m : m;
    repeat (len - 1) @(negedge clk);
    start = 0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    item_t e;
    clear_cov();
    forever begin
      @(posedge clk); #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        check(e.req, drive == e.drv, "drive", int'(drive), int'(e.drv));
        check(e.act ? "R2" : "R6", vec_idx == e.idx, "vec_idx", int'(vec_idx), int'(e.idx));
        check("R6", done == e.dn, "done", int'(done), int'(e.dn));
        if (e.act)
          for (int i = 0; i < N; i++) for (int j = 0; j < N; j++)
            cov[i][j][{drive[i], drive[j]}] = 1'b1;
        if (e.dn) begin
          for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
              if (msel(e.md, i) != msel(e.md, j))
                check("R8", cov[i][j] == 4'hF, "pair combos", int'(cov[i][j]), 15);
          clear_cov();
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", drive == '0, "drive in reset", int'(drive), 0);
    check("R1", vec_idx == 0, "vec_idx in reset", int'(vec_idx), 0);
    check("R1", done == 0, "done in reset", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", drive == '0 && done == 0, "outputs after reset", int'(drive), 0);
    run_seq(1'b0, 1'b0);
    run_seq(1'b1, 1'b0);
    run_seq(1'b0, 1'b1);
    run_seq(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    check("R7", done == 0 && drive == '0, "idle after disturbed runs", int'(done), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule